// File: doc/BRIEF.md
# Split or Unified Up-Counter with Match Reload

This block is a free-running up-counter that can be configured as two independent halves or as one double-width counter. In split mode, the low half and the high half each count while their own enable input is high. Each half wraps to zero after it reaches all ones. In unified mode the two halves form one counter of twice the width. The low enable drives it, and a carry crosses from the top bit of the low half into the high half. The half width is a parameter; the default is 16, which gives a 32-bit unified count.

Each half has a match register and a reload register. A match output pulses for one cycle when its counter is about to leave the matched value. When a counter wraps, the match register takes the value of its reload register, unless a hold bit in the configuration blocks the refresh. In unified mode that hold bit covers both halves.

Software uses a 32-bit write-only register port, and only full-word writes are accepted. A mode state machine follows the configuration. It has two states, SPLIT and UNIFIED. The transition SPLIT to UNIFIED happens on the first clock after the unify bit reads 1. The transition UNIFIED to SPLIT happens on the first clock after the unify bit reads 0. The cycle in which the state and the unify bit disagree is the clear cycle.

Top module: `split_unified_timer`

## Requirements
- R1: After reset, the block is in SPLIT state, both counters read 0, the configuration bits are 0, and all match and reload registers are 0.
- R2: In SPLIT state, each half adds one on every clock where its own enable is high. A half goes from all ones to 0, and the low half never changes the high half.
- R3: In UNIFIED state, the pair {cnt_hi, cnt_lo} adds one on every clock where en_lo is high. When cnt_lo passes all ones, cnt_hi adds one. The input en_hi has no effect.
- R4: In SPLIT state, a half's match output is high in a cycle when its enable is high and its counter equals its match register. In UNIFIED state, match_lo is high when en_lo is high and the full count equals {match_hi_reg, match_lo_reg}, and match_hi stays 0.
- R5: When a half wraps (enable high and counter all ones), its match register holds its reload value from the next cycle on. In UNIFIED state, a full wrap refreshes both match registers.
- R6: Configuration bit 1 (hold) blocks the low reload in SPLIT state and blocks both reloads in UNIFIED state. In SPLIT state the high reload is not affected by it.
- R7: A write with wr_word low raises wr_err in the same cycle and changes no register. A full-word write changes the register at its offset: 0 is configuration (bit 0 unify, bit 1 hold), 1 is low match, 2 is high match, 3 is low reload, 4 is high reload. Match and reload registers take the low bits of wr_data.
- R8: The cycle after a write that changes the unify bit is a clear cycle. Both counters read 0 in the next cycle, and no match pulse or reload occurs in the clear cycle.
- R9: A full-word write to a match register in the cycle that half wraps takes priority over the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write strobe |
| wr_word | input | 1 | 1 for a full 32-bit write, 0 for a half-word write |
| wr_addr | input | ADDR_W | Word offset of the written register |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | Error response for a rejected write |
| en_lo | input | 1 | Count enable for the low half; drives the whole count in unified mode |
| en_hi | input | 1 | Count enable for the high half |
| cnt_lo | output | HALF_W | Low counter value |
| cnt_hi | output | HALF_W | High counter value |
| match_lo | output | 1 | Low or unified match pulse |
| match_hi | output | 1 | High match pulse |

## Verification
Two functions can fall in the same cycle. The first pair is a register write and a reload: a bus write to a match register can land in the cycle that half wraps. The bench steers this case from its own model of the counter, waiting until the counter holds all ones with the enable high, and the model expects the written value to win. The second pair is a mode change and counting or matching: the clear cycle can fall where a wrap or a match would otherwise occur. The model expects zeros afterwards and no pulse, and it compares every output on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [0:0] {
        MODE_SPLIT   = 1'b0,
        MODE_UNIFIED = 1'b1
    } mode_e;

    localparam int CFG_UNIFY_BIT = 0;
    localparam int CFG_HOLD_BIT  = 1;

    localparam int ADR_CFG    = 0;
    localparam int ADR_MAT_LO = 1;
    localparam int ADR_MAT_HI = 2;
    localparam int ADR_REL_LO = 3;
    localparam int ADR_REL_HI = 4;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_word,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  mode_e             mode,
    input  logic              wrap_lo,
    input  logic              wrap_hi,
    output logic              wr_err,
    output logic              cfg_unify,
    output logic              cfg_hold,
    output logic [HALF_W-1:0] mat_lo,
    output logic [HALF_W-1:0] mat_hi
);
    logic [HALF_W-1:0] rel_lo, rel_hi;
    logic wr_ok, sel_cfg, sel_mlo, sel_mhi, sel_rlo, sel_rhi;
    logic rl_lo, rl_hi;
    logic unused_upper;

    assign unused_upper = ^wr_data[DATA_W-1:HALF_W];

    always_comb begin
        wr_ok   = wr_valid & wr_word;
        wr_err  = wr_valid & ~wr_word;
        sel_cfg = wr_ok && (wr_addr == ADDR_W'(ADR_CFG));
        sel_mlo = wr_ok && (wr_addr == ADDR_W'(ADR_MAT_LO));
        sel_mhi = wr_ok && (wr_addr == ADDR_W'(ADR_MAT_HI));
        sel_rlo = wr_ok && (wr_addr == ADDR_W'(ADR_REL_LO));
        sel_rhi = wr_ok && (wr_addr == ADDR_W'(ADR_REL_HI));
        rl_lo   = wrap_lo & ~cfg_hold;
        rl_hi   = wrap_hi & ((mode == MODE_UNIFIED) ? ~cfg_hold : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_unify <= 1'b0;
            cfg_hold  <= 1'b0;
            mat_lo    <= '0;
            mat_hi    <= '0;
            rel_lo    <= '0;
            rel_hi    <= '0;
        end else begin
            if (sel_cfg) begin
                cfg_unify <= wr_data[CFG_UNIFY_BIT];
                cfg_hold  <= wr_data[CFG_HOLD_BIT];
            end
            if (sel_mlo)    mat_lo <= wr_data[HALF_W-1:0];
            else if (rl_lo) mat_lo <= rel_lo;
            if (sel_mhi)    mat_hi <= wr_data[HALF_W-1:0];
            else if (rl_hi) mat_hi <= rel_hi;
            if (sel_rlo)    rel_lo <= wr_data[HALF_W-1:0];
            if (sel_rhi)    rel_hi <= wr_data[HALF_W-1:0];
        end
    end

    // R7: a rejected write leaves the configuration untouched
    assert_err_keeps_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> $stable({cfg_unify, cfg_hold}));

    // R9: a bus write to the low match register beats a same-cycle reload
    assert_bus_beats_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_mlo |=> (mat_lo == $past(wr_data[HALF_W-1:0])));

    // R6: hold keeps the low match register through a wrap
    assert_hold_blocks_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_lo && cfg_hold && !sel_mlo) |=> $stable(mat_lo));
endmodule

// File: rtl/tmr_mode_fsm.sv
module tmr_mode_fsm
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cfg_unify,
    output mode_e mode,
    output logic  clear
);
    mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_SPLIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SPLIT:   if (cfg_unify)  state_d = MODE_UNIFIED;
            MODE_UNIFIED: if (!cfg_unify) state_d = MODE_SPLIT;
            default:      state_d = MODE_SPLIT;
        endcase
    end

    always_comb begin
        mode  = state_q;
        clear = (state_d != state_q);
    end

    // R8: every clear cycle is followed by a change of mode
    assert_clear_moves_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mode != $past(mode)));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              clear,
    input  logic              en_lo,
    input  logic              en_hi,
    input  logic [HALF_W-1:0] mat_lo,
    input  logic [HALF_W-1:0] mat_hi,
    output logic [HALF_W-1:0] cnt_lo,
    output logic [HALF_W-1:0] cnt_hi,
    output logic              wrap_lo,
    output logic              wrap_hi,
    output logic              hit_lo,
    output logic              hit_hi
);
    localparam int FULL_W = 2 * HALF_W;
    localparam logic [HALF_W-1:0] HALF_MAX = '1;

    logic [FULL_W-1:0] full_nxt;
    logic lo_top, hi_top, lo_eq, hi_eq;

    always_comb begin
        lo_top   = (cnt_lo == HALF_MAX);
        hi_top   = (cnt_hi == HALF_MAX);
        lo_eq    = (cnt_lo == mat_lo);
        hi_eq    = (cnt_hi == mat_hi);
        full_nxt = {cnt_hi, cnt_lo} + 1'b1;
        wrap_lo  = 1'b0;
        wrap_hi  = 1'b0;
        hit_lo   = 1'b0;
        hit_hi   = 1'b0;
        if (!clear) begin
            unique case (mode)
                MODE_SPLIT: begin
                    wrap_lo = en_lo & lo_top;
                    wrap_hi = en_hi & hi_top;
                    hit_lo  = en_lo & lo_eq;
                    hit_hi  = en_hi & hi_eq;
                end
                MODE_UNIFIED: begin
                    wrap_lo = en_lo & lo_top & hi_top;
                    wrap_hi = en_lo & lo_top & hi_top;
                    hit_lo  = en_lo & lo_eq & hi_eq;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (clear) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (mode == MODE_UNIFIED) begin
            if (en_lo) {cnt_hi, cnt_lo} <= full_nxt;
        end else begin
            if (en_lo) cnt_lo <= cnt_lo + 1'b1;
            if (en_hi) cnt_hi <= cnt_hi + 1'b1;
        end
    end

    // R2: in split mode the high half only moves with its own enable
    assert_no_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SPLIT && !clear && !en_hi) |=> $stable(cnt_hi));

    // R2: a wrapping low half lands on zero
    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_lo |=> (cnt_lo == '0));

    // R3: unified carry crosses into the high half
    assert_carry_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UNIFIED && !clear && en_lo && cnt_lo == HALF_MAX)
        |=> (cnt_hi == HALF_W'($past(cnt_hi) + 1'b1)));

    // R8: a clear cycle leaves both halves at zero
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_lo == '0 && cnt_hi == '0));

    // R4: no high match pulse in unified mode
    assert_unified_hi_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UNIFIED) |-> !hit_hi);
endmodule

// File: rtl/split_unified_timer.sv
module split_unified_timer
    import tmr_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_word,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    input  logic              en_lo,
    input  logic              en_hi,
    output logic [HALF_W-1:0] cnt_lo,
    output logic [HALF_W-1:0] cnt_hi,
    output logic              match_lo,
    output logic              match_hi
);
    mode_e mode;
    logic clear, cfg_unify, cfg_hold, wrap_lo, wrap_hi;
    logic [HALF_W-1:0] mat_lo, mat_hi;

    tmr_regs #(.HALF_W(HALF_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode(mode),
        .wrap_lo(wrap_lo), .wrap_hi(wrap_hi), .wr_err(wr_err),
        .cfg_unify(cfg_unify), .cfg_hold(cfg_hold),
        .mat_lo(mat_lo), .mat_hi(mat_hi)
    );

    tmr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_unify(cfg_unify),
        .mode(mode), .clear(clear)
    );

    tmr_count #(.HALF_W(HALF_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .mode(mode), .clear(clear),
        .en_lo(en_lo), .en_hi(en_hi), .mat_lo(mat_lo), .mat_hi(mat_hi),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .wrap_lo(wrap_lo), .wrap_hi(wrap_hi),
        .hit_lo(match_lo), .hit_hi(match_hi)
    );
endmodule

// File: tb/sim_split_unified_timer.sv
`timescale 1ns/1ps
module sim_split_unified_timer;
    localparam int HW   = 4;
    localparam int HMAX = (1 << HW) - 1;
    localparam int FMAX = (1 << (2 * HW)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, wr_word = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic en_lo = 1'b0, en_hi = 1'b0;
    logic wr_err, match_lo, match_hi;
    logic [HW-1:0] cnt_lo, cnt_hi;

    always #2.5 clk = ~clk;

    split_unified_timer #(.HALF_W(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
        .en_lo(en_lo), .en_hi(en_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .match_lo(match_lo), .match_hi(match_hi)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    string phase = "R1 reset";

    // reference model state
    int m_unify, m_hold, m_state, mlo, mhi, rlo, rhi, c_lo, c_hi;

    task automatic cmp(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL [%s] %s: got %0d expected %0d", phase, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            m_unify = 0; m_hold = 0; m_state = 0;
            mlo = 0; mhi = 0; rlo = 0; rhi = 0; c_lo = 0; c_hi = 0;
        end else begin
            int clr, full, e_hlo, e_hhi, wlo, whi, n_mlo, n_mhi, a, d;
            clr = (m_state != m_unify);
            full = c_hi * (HMAX + 1) + c_lo;
            e_hlo = 0; e_hhi = 0; wlo = 0; whi = 0;
            if (!clr) begin
                if (m_state == 1) begin
                    e_hlo = en_lo && (full == mhi * (HMAX + 1) + mlo);
                    wlo = en_lo && (full == FMAX);
                    whi = wlo;
                end else begin
                    e_hlo = en_lo && (c_lo == mlo);
                    e_hhi = en_hi && (c_hi == mhi);
                    wlo = en_lo && (c_lo == HMAX);
                    whi = en_hi && (c_hi == HMAX);
                end
            end
            cmp("R2/R3 cnt_lo", cnt_lo, c_lo);
            cmp("R2/R3 cnt_hi", cnt_hi, c_hi);
            cmp("R4 match_lo", match_lo, e_hlo);
            cmp("R4 match_hi", match_hi, e_hhi);
            cmp("R7 wr_err", wr_err, wr_valid && !wr_word);
            // advance the model to the state after the coming edge
            n_mlo = mlo; n_mhi = mhi;
            if (wlo && !m_hold) n_mlo = rlo;
            if (whi && (m_state == 1 ? !m_hold : 1)) n_mhi = rhi;
            if (clr) begin
                c_lo = 0; c_hi = 0;
            end else if (m_state == 1) begin
                if (en_lo) begin
                    full = (full + 1) % (FMAX + 1);
                    c_lo = full % (HMAX + 1);
                    c_hi = full / (HMAX + 1);
                end
            end else begin
                if (en_lo) c_lo = (c_lo + 1) % (HMAX + 1);
                if (en_hi) c_hi = (c_hi + 1) % (HMAX + 1);
            end
            m_state = m_unify;
            if (wr_valid && wr_word) begin
                a = wr_addr; d = wr_data[HW-1:0];
                if (a == 0) begin m_unify = wr_data[0]; m_hold = wr_data[1]; end
                if (a == 1) n_mlo = d;
                if (a == 2) n_mhi = d;
                if (a == 3) rlo = d;
                if (a == 4) rhi = d;
            end
            mlo = n_mlo; mhi = n_mhi;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bw(input int a, input int d, input bit word);
        wr_valid = 1'b1; wr_word = word; wr_addr = 3'(a); wr_data = 32'(d);
        step();
        wr_valid = 1'b0; wr_word = 1'b0;
    endtask

    task automatic run(input int n, input int pat);
        for (int i = 0; i < n; i++) begin
            if (pat == 1) en_hi = (i % 3) != 0;
            if (pat == 2) en_lo = (i % 5) != 4;
            step();
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired in phase %s: got hang expected completion", phase);
        finish_up();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        phase = "R1 reset";
        run(4, 0);
        phase = "R7 half-word write rejected";
        bw(0, 1, 1'b0);
        bw(1, 5, 1'b0);
        run(3, 0);
        phase = "R7 word writes";
        bw(1, 5, 1'b1); bw(2, 3, 1'b1); bw(3, 9, 1'b1); bw(4, 2, 1'b1);
        phase = "R2 split counting with reload R5";
        en_lo = 1'b1;
        run(40, 1);
        run(20, 2);
        phase = "R6 hold in split";
        bw(3, 7, 1'b1);
        bw(0, 2, 1'b1);
        en_lo = 1'b1;
        run(40, 1);
        phase = "R9 write at wrap";
        bw(0, 0, 1'b1);
        bw(3, 11, 1'b1);
        en_lo = 1'b1; en_hi = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (c_lo == HMAX) break;
            step();
        end
        bw(1, 2, 1'b1);
        run(20, 0);
        phase = "R8 switch to unified";
        en_lo = 1'b1; en_hi = 1'b1;
        run(5, 0);
        bw(0, 1, 1'b1);
        run(3, 0);
        phase = "R3 unified counting";
        bw(1, 4, 1'b1); bw(2, 1, 1'b1); bw(3, 6, 1'b1); bw(4, 2, 1'b1);
        en_lo = 1'b1;
        run(300, 1);
        run(100, 2);
        phase = "R6 hold in unified";
        bw(3, 1, 1'b1); bw(4, 3, 1'b1);
        bw(0, 3, 1'b1);
        en_lo = 1'b1;
        run(300, 1);
        phase = "R8 switch to split";
        bw(0, 0, 1'b1);
        en_lo = 1'b1;
        run(40, 1);
        phase = "R8 toggle back to back";
        bw(0, 1, 1'b1);
        bw(0, 0, 1'b1);
        run(30, 1);
        en_lo = 1'b0; en_hi = 1'b0;
        run(3, 0);
        finish_up();
    end
endmodule